// File: doc/BRIEF.md
# Reset Pulse Controller

This block holds the settings for an external reset pulse and produces that pulse. Software writes one 32-bit configuration word. The low 20 bits of every write become the pulse length. The top byte of the same write is a command byte. Four command values change the pulse polarity or the pin drive style. Any other value leaves both settings as they were. The word can be read back at any time.

When the neighbouring watchdog raises its trigger, the block starts a reset pulse. The pulse lasts the programmed width plus one tick periods. A tick is a single-cycle enable from a shared timebase. A trigger that arrives while a pulse is running is dropped. The pin is presented as an output-enable and value pair. In push-pull mode the block always drives the pin. In open-drain mode it drives a low level only and otherwise releases the pin.

Top module: `rst_pulse_ctl`

## Requirements
- R1: After a synchronous active-low reset, `rd_data` is 0x000000FF (width 0xFF, active-low, open-drain), `pin_oe` is 0 and `pin_val` is 0.
- R2: Every write copies `wr_data[19:0]` into the width field, whatever the command byte.
- R3: A write whose `wr_data[31:24]` is 0xA5 selects an active-high pulse (bit 31 = 1). A command byte of 0x5A selects an active-low pulse (bit 31 = 0).
- R4: A write whose `wr_data[31:24]` is 0xA8 selects push-pull drive (bit 30 = 1). A command byte of 0x8A selects open-drain drive (bit 30 = 0).
- R5: Any other command byte, zero included, leaves bits 31 and 30 unchanged. Data bits 23:20 are never stored.
- R6: `rd_data` is combinational from the stored word: bit 31 is polarity, bit 30 is drive type, bits 19:0 are width, and every other bit reads 0.
- R7: While idle, a trigger sampled on a clock edge starts a pulse at that edge. The pulse ends on the (width+1)-th later edge at which `tick` is 1.
- R8: A trigger sampled while a pulse is active is ignored, including one on the edge that ends the pulse. The pulse length is unchanged and no new pulse follows.
- R9: In push-pull mode `pin_oe` is always 1. `pin_val` carries the active level during a pulse and the opposite level otherwise.
- R10: In open-drain mode `pin_val` is always 0. `pin_oe` is 1 exactly when the pin level would be low: during a pulse when active-low, outside a pulse when active-high.
- R11: The width is captured when the pulse starts, so a write during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Write data; bits 31:24 are the command byte, bits 19:0 are the width |
| rd_data | output | 32 | Stored configuration word |
| tick | input | 1 | Timebase enable; one pulse-length unit per asserted cycle |
| trigger | input | 1 | Start request from the watchdog |
| pin_oe | output | 1 | Pin output enable |
| pin_val | output | 1 | Pin value while enabled |

## Verification
A write is visible on `rd_data` straight after the clock edge that accepts it, with no further delay. The bench therefore drives each write on a falling edge and compares it on the next falling edge. The pins follow the pulse state with no register in between. They change just after the edge that takes a trigger, and just after the edge carrying the (width+1)-th tick. The bench counts the ticks it drives while it sees the pulse active on the pins, and compares that count with width+1. After every pulse it samples two more falling edges to confirm that a dropped trigger started nothing.

// File: rtl/rpc_pkg.sv
// Package: shared constants and types for the reset pulse controller.
// Assumes the command byte sits in the top eight bits of the data word.
package rpc_pkg;

    // Command byte values carried in the top byte of a write
    localparam logic [7:0] CMD_ACT_HIGH   = 8'hA5;
    localparam logic [7:0] CMD_ACT_LOW    = 8'h5A;
    localparam logic [7:0] CMD_PUSH_PULL  = 8'hA8;
    localparam logic [7:0] CMD_OPEN_DRAIN = 8'h8A;

    // Pin behaviour selected by the configuration word
    typedef struct packed {
        logic act_high;   // 1: pulse drives high, 0: pulse drives low
        logic push_pull;  // 1: always driven, 0: drive-low-only
    } pin_mode_t;

endpackage

// File: rtl/rpc_cfg_reg.sv
// Module: configuration word for the reset pulse.
// Every write replaces the width. The command byte may change the polarity or the
// drive type. Reads are combinational. Assumes WID_W <= DATA_W - 10.
module rpc_cfg_reg
    import rpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WID_W  = 20,
    parameter logic [WID_W-1:0] RST_WIDTH = WID_W'(8'hFF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [WID_W-1:0]  width,
    output pin_mode_t         mode,
    output logic [DATA_W-1:0] rd_data
);

    localparam int CMD_LSB = DATA_W - 8;
    localparam int POL_BIT = DATA_W - 1;
    localparam int DRV_BIT = DATA_W - 2;

    logic [7:0] cmd;
    assign cmd = wr_data[DATA_W-1:CMD_LSB];

    // Bits between the width and the command byte are never stored
    logic unused_gap_bits;
    assign unused_gap_bits = ^wr_data[CMD_LSB-1:WID_W];

    // Width register: reloaded from the low data bits on every write
    always_ff @(posedge clk) begin
        if (!rst_n)     width <= RST_WIDTH;
        else if (wr_en) width <= wr_data[WID_W-1:0];
    end

    // Mode bits: changed only by a matching command byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '{act_high: 1'b0, push_pull: 1'b0};
        end else if (wr_en) begin
            case (cmd)
                CMD_ACT_HIGH:   mode.act_high  <= 1'b1;
                CMD_ACT_LOW:    mode.act_high  <= 1'b0;
                CMD_PUSH_PULL:  mode.push_pull <= 1'b1;
                CMD_OPEN_DRAIN: mode.push_pull <= 1'b0;
                default: ;
            endcase
        end
    end

    // Read word assembly: unused bits read as zero
    always_comb begin
        rd_data          = '0;
        rd_data[WID_W-1:0] = width;
        rd_data[POL_BIT] = mode.act_high;
        rd_data[DRV_BIT] = mode.push_pull;
    end

    AST_WIDTH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> width == $past(wr_data[WID_W-1:0])); // R2
    AST_POL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cmd == CMD_ACT_HIGH |=> mode.act_high); // R3
    AST_DRV_PP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cmd == CMD_PUSH_PULL |=> mode.push_pull); // R4
    AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && cmd != CMD_ACT_HIGH && cmd != CMD_ACT_LOW &&
        cmd != CMD_PUSH_PULL && cmd != CMD_OPEN_DRAIN |=> $stable(mode)); // R5

endmodule

// File: rtl/rpc_pulse_timer.sv
// Module: pulse length timer.
// An idle trigger snapshots the width and starts the pulse. Each tick counts down
// once, and the tick seen at zero ends the pulse. Triggers while busy are dropped.
module rpc_pulse_timer #(
    parameter int WID_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trigger,
    input  logic [WID_W-1:0] load_width,
    output logic             busy
);

    localparam logic [WID_W-1:0] ONE = WID_W'(1);

    logic [WID_W-1:0] remain;

    // Start, count down and finish the pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            remain <= '0;
        end else if (!busy) begin
            if (trigger) begin
                busy   <= 1'b1;
                remain <= load_width;
            end
        end else if (tick) begin
            if (remain == '0) busy   <= 1'b0;
            else              remain <= remain - ONE;
        end
    end

    AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && trigger |=> busy && remain == $past(load_width)); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !tick |=> busy && $stable(remain)); // R7
    AST_BUSY_TRIG_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy && trigger && tick && remain != '0 |=> busy && remain == $past(remain) - ONE); // R8

endmodule

// File: rtl/rpc_pin_drive.sv
// Module: maps pulse state and mode onto the output-enable/value pair.
// Push-pull always drives. Open-drain drives low only and releases otherwise.
module rpc_pin_drive
    import rpc_pkg::*;
(
    input  logic      busy,
    input  pin_mode_t mode,
    output logic      pin_oe,
    output logic      pin_val
);

    logic level;

    // Pin level: active polarity during a pulse, opposite when idle
    always_comb begin
        level   = busy ? mode.act_high : ~mode.act_high;
        pin_oe  = mode.push_pull ? 1'b1 : ~level;
        pin_val = mode.push_pull ? level : 1'b0;
    end

endmodule

// File: rtl/rst_pulse_ctl.sv
// Module: reset pulse controller top.
// Joins the configuration word, the pulse timer and the pin stage.
// Assumes tick is a single-cycle enable synchronous to clk.
module rst_pulse_ctl
    import rpc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int WID_W  = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    input  logic              trigger,
    output logic              pin_oe,
    output logic              pin_val
);

    logic [WID_W-1:0] width;
    pin_mode_t        mode;
    logic             busy;

    rpc_cfg_reg #(.DATA_W(DATA_W), .WID_W(WID_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .width(width), .mode(mode), .rd_data(rd_data)
    );

    rpc_pulse_timer #(.WID_W(WID_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .trigger(trigger),
        .load_width(width), .busy(busy)
    );

    rpc_pin_drive u_drive (
        .busy(busy), .mode(mode), .pin_oe(pin_oe), .pin_val(pin_val)
    );

    AST_PP_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        mode.push_pull |-> pin_oe); // R9
    AST_OD_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode.push_pull |-> !pin_val); // R10

endmodule

// File: tb/rst_pulse_ctl_bench.sv
`timescale 1ns/1ps
module rst_pulse_ctl_bench;

    logic        clk = 1'b0;
    logic        rst_n, wr_en, tick, trigger;
    logic [31:0] wr_data, rd_data;
    logic        pin_oe, pin_val;
    int          n_chk = 0, n_bad = 0;
    logic [31:0] model;
    bit          done = 0;

    always #2 clk = ~clk;

    rst_pulse_ctl u_rst_pulse_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .tick(tick), .trigger(trigger),
        .pin_oe(pin_oe), .pin_val(pin_val)
    );

    // Expected word after a write, from R2..R6
    function automatic logic [31:0] next_word(input logic [31:0] old, input logic [31:0] d);
        logic [31:0] r;
        r = old & 32'hC000_0000;
        r[19:0] = d[19:0];
        case (d[31:24])
            8'hA5: r[31] = 1'b1;
            8'h5A: r[31] = 1'b0;
            8'hA8: r[30] = 1'b1;
            8'h8A: r[30] = 1'b0;
            default: ;
        endcase
        return r;
    endfunction

    // Pulse seen at the pins, from R9 and R10
    function automatic bit pins_active(input logic oe, input logic val, input logic pol, input logic pp);
        if (pp) return val == pol;
        return pol ? !oe : oe;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic write_word(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model = next_word(model, d);
    endtask

    // One pulse; mid_trig_at / mid_wr_at give the tick index for extra stimulus (-1 = none)
    task automatic run_pulse(input int w, input bit pol, input bit pp, input bit rnd_tick,
                             input int mid_trig_at, input int mid_wr_at);
        int  ticks = 0, guard = 0;
        bit  mode_ok = 1, act;
        write_word({pol ? 8'hA5 : 8'h5A, 4'h0, 20'(w)});
        write_word({pp ? 8'hA8 : 8'h8A, 4'h0, 20'(w)});
        check("R9/R10 idle pins", 32'(pins_active(pin_oe, pin_val, pol, pp)), 32'd0);
        trigger = 1'b1; tick = rnd_tick ? 1'($urandom) : 1'b1;
        @(negedge clk);
        trigger = 1'b0;
        act = pins_active(pin_oe, pin_val, pol, pp);
        while (act && guard < 5000) begin
            if (pp && !pin_oe) mode_ok = 0;
            if (!pp && pin_val) mode_ok = 0;
            tick    = rnd_tick ? 1'($urandom) : 1'b1;
            trigger = (ticks == mid_trig_at);
            if (ticks == mid_wr_at) begin
                wr_en = 1'b1; wr_data = {8'h00, 4'h0, 20'(w + 7)};
                model = next_word(model, wr_data);
            end
            if (tick) ticks++;
            @(negedge clk);
            wr_en = 1'b0; trigger = 1'b0;
            guard++;
            act = pins_active(pin_oe, pin_val, pol, pp);
        end
        check(pp ? "R9 drive style" : "R10 drive style", 32'(mode_ok), 32'd1);
        check("R7/R8/R11 pulse ticks", 32'(ticks), 32'(w + 1));
        tick = 1'b0;
        @(negedge clk);
        check("R8 no retrigger", 32'(pins_active(pin_oe, pin_val, pol, pp)), 32'd0);
        @(negedge clk);
        check("R8 still idle", 32'(pins_active(pin_oe, pin_val, pol, pp)), 32'd0);
        check("R11 config after pulse", rd_data, model);
    endtask

    initial begin
        void'($urandom(32'd2718));
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; tick = 1'b0; trigger = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model = 32'h0000_00FF;
        check("R1 reset word", rd_data, 32'h0000_00FF);
        check("R1 reset oe", 32'(pin_oe), 32'd0);
        check("R1 reset val", 32'(pin_val), 32'd0);

        // Directed command decode
        write_word(32'hA500_0010); check("R3 active-high", rd_data, 32'h8000_0010);
        write_word(32'h7700_0055); check("R5 unknown cmd keeps", rd_data, 32'h8000_0055);
        write_word(32'h5A00_0011); check("R3 active-low", rd_data, 32'h0000_0011);
        write_word(32'hA80F_FFFF); check("R4 push-pull", rd_data, 32'h400F_FFFF);
        write_word(32'h00F0_0123); check("R5/R6 gap bits dropped", rd_data, 32'h4000_0123);
        write_word(32'h8A00_0000); check("R4 open-drain", rd_data, 32'h0000_0000);
        write_word(32'h3FFF_FFFF); check("R2/R6 width only", rd_data, 32'h000F_FFFF);

        // Random writes mixing command bytes
        for (int i = 0; i < 40; i++) begin
            logic [31:0] d;
            logic [7:0]  c;
            d = $urandom;
            case ($urandom % 6)
                0: c = 8'hA5; 1: c = 8'h5A; 2: c = 8'hA8; 3: c = 8'h8A;
                default: c = 8'($urandom);
            endcase
            write_word({c, d[23:0]});
            check("R2..R6 random write", rd_data, model);
        end

        // Pulses across modes with random ticks
        for (int m = 0; m < 4; m++)
            run_pulse(int'($urandom % 16), m[0], m[1], 1'b1, -1, -1);
        run_pulse(0, 1'b0, 1'b1, 1'b0, -1, -1);      // R7 width zero
        run_pulse(300, 1'b1, 1'b0, 1'b0, -1, -1);    // R7 longer pulse
        run_pulse(9, 1'b0, 1'b0, 1'b1, 3, -1);       // R8 mid-pulse trigger
        run_pulse(4, 1'b1, 1'b1, 1'b0, 4, -1);       // R8 trigger on final edge
        run_pulse(10, 1'b0, 1'b1, 1'b1, -1, 2);      // R11 width write during pulse

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule